// File: doc/BRIEF.md
# System Control Register File

This block holds the privileged control registers that a processor core reaches through its move-to and move-from control instructions. Each access names a register with a 5-bit number and a 3-bit select. A write passes the data through a mask that belongs to the target register. Bits that the mask protects keep their stored value, and bits that are not implemented stay at zero. A read returns the register value on the cycle after the access, together with a valid strobe.

The user, exception-level, error-level and debug-mode flags are kept as separate flip-flops. The core uses them directly, and they are merged into the Status and Debug values when those registers are read. Two side effects leave the block: a one-cycle flush pulse when a write to the translation entry-high register changes its address-space ID, and a level interrupt request. A Status write that enables interrupts while one is already pending and unmasked raises that request at once. The timer, the random-index generator and the bad-address and link-address capture logic sit outside the block. Their current values come in on input ports, and writes aimed at the count and compare registers are passed out as strobes.

Top module: `sysctl_regfile`

## Requirements
- R1: An access with a nonzero select is invalid unless the register number is 16 or 28. At 16 and 28, only selects 0 and 1 are valid. An invalid write changes no state and produces no side effect. An invalid read returns zero.
- R2: A write to Index (number 0) loads bits 3:0 from the data and keeps the stored bit 31, which is 0 after reset. All other bits read as zero.
- R3: A write to EntryLo0 (2) or EntryLo1 (3) stores data bits 29:0 and clears bits 31:30.
- R4: A write to Context (4) keeps the stored bits 31:24 and loads bits 23:4 from the data. Bits 3:0 always read zero.
- R5: The following registers store the data ANDed with a fixed mask:
  - PageMask (5): 0x01FFE000
  - Wired (6): 0x0000000F
  - WatchHi (19): 0x40FF0FF8
  - TagLo (28, select 0): 0xFFFFFCF6

  Cause (13) loads bits 23, 22, 9 and 8 and keeps the bits in 0xB000F87C. Config0 (16, select 0) loads bit 0 and keeps the bits in 0xFE17FF80. Config1 (16, select 1) reads a fixed parameter value.
- R6: A write to EntryHi (10) stores the data ANDed with 0xFFFFF0FF. When data bits 7:0 differ from the stored bits 7:0, the flush output is high for exactly the one cycle after the write.
- R7: A write to Status (12) stores the data ANDed with 0xFA78FF01 and loads the user (bit 4), error-level (bit 2) and exception-level (bit 1) flags from the data. A read of Status returns the stored value ORed with these flags at those bit positions.
- R8: The interrupt request rises in the cycle after a Status write when all of the following hold:
  - data bit 0 (IE) is 1 and the stored IE was 0;
  - data bits 2:1 are both 0;
  - the debug flag is 0;
  - data bits 15:8 AND Cause bits 15:8 is nonzero.

  No other event raises the request.
- R9: A Status write with data bit 0 equal to 0, while the stored IE is 1, clears the interrupt request in the next cycle. Any other write leaves the request unchanged.
- R10: A read of LLAddr (17) returns the link-address input shifted right by 4.
- R11: A write to Debug (23) keeps the bits in 0x8C03FC1F, loads the bits in 0x13300120, and loads the debug flag from data bit 30. A read of Debug ORs the flag in at bit 30.
- R12: Register numbers 7, 20, 21, 22, 25, 26, 27 and 29 read zero and ignore writes. Reads of Random (1), BadVAddr (8), Count (9) and Compare (11) return their input ports. PRId (15) returns a parameter value.
- R13: A write to Count (9) or Compare (11) pulses the matching strobe output for one cycle and puts the write data on the timer data output.
- R14: A read access yields read-valid and the read data in the cycle after the access. Read-valid is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| acc_num | input | 5 | Register number |
| acc_sel | input | 3 | Register select |
| acc_wdata | input | 32 | Write data |
| rnd_in | input | 32 | Current random index value |
| count_in | input | 32 | Current timer count |
| compare_in | input | 32 | Current timer compare value |
| badva_in | input | 32 | Last faulting address |
| ll_addr_in | input | 32 | Stored link address |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| asid_flush | output | 1 | One-cycle pulse on address-space ID change |
| irq_req | output | 1 | Hard interrupt request level |
| mode_user | output | 1 | User-mode flag |
| mode_exl | output | 1 | Exception-level flag |
| mode_erl | output | 1 | Error-level flag |
| mode_debug | output | 1 | Debug-mode flag |
| cnt_wr | output | 1 | Count write strobe |
| cmp_wr | output | 1 | Compare write strobe |
| tmr_wdata | output | 32 | Data for the timer write strobes |

## Verification
The hardest state to reach is an immediate interrupt request. It needs Cause to hold a pending software bit, Status to have interrupts disabled, the exception, error and debug flags all clear, and then a Status write that sets IE with a matching mask bit. The stimulus first cleans the debug and mode flags left by the register-mask table. It then walks Status and Cause through each blocking condition in turn: no pending bit, exception level set, debug set, and IE already set. Each of these shows no request, before the case where the request rises and is later withdrawn.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned DW = 32;

  // register numbers whose position is decoded by the core
  localparam logic [4:0] RN_INDEX  = 5'd0;
  localparam logic [4:0] RN_RANDOM = 5'd1;
  localparam logic [4:0] RN_ELO0   = 5'd2;
  localparam logic [4:0] RN_ELO1   = 5'd3;
  localparam logic [4:0] RN_CTX    = 5'd4;
  localparam logic [4:0] RN_PMASK  = 5'd5;
  localparam logic [4:0] RN_WIRED  = 5'd6;
  localparam logic [4:0] RN_BADVA  = 5'd8;
  localparam logic [4:0] RN_COUNT  = 5'd9;
  localparam logic [4:0] RN_EHI    = 5'd10;
  localparam logic [4:0] RN_CMP    = 5'd11;
  localparam logic [4:0] RN_STATUS = 5'd12;
  localparam logic [4:0] RN_CAUSE  = 5'd13;
  localparam logic [4:0] RN_EPC    = 5'd14;
  localparam logic [4:0] RN_PRID   = 5'd15;
  localparam logic [4:0] RN_CONFIG = 5'd16;
  localparam logic [4:0] RN_LLADDR = 5'd17;
  localparam logic [4:0] RN_WLO    = 5'd18;
  localparam logic [4:0] RN_WHI    = 5'd19;
  localparam logic [4:0] RN_DEBUG  = 5'd23;
  localparam logic [4:0] RN_DEPC   = 5'd24;
  localparam logic [4:0] RN_CACHE  = 5'd28;
  localparam logic [4:0] RN_ERREPC = 5'd30;
  localparam logic [4:0] RN_SAVE   = 5'd31;

  // write masks: LOAD bits come from data, KEEP bits hold old value
  localparam logic [DW-1:0] ELO_LOAD   = 32'h3FFF_FFFF;
  localparam logic [DW-1:0] PMASK_LOAD = 32'h01FF_E000;
  localparam logic [DW-1:0] EHI_LOAD   = 32'hFFFF_F0FF;
  localparam logic [DW-1:0] STAT_LOAD  = 32'hFA78_FF01;
  localparam logic [DW-1:0] CAUSE_KEEP = 32'hB000_F87C;
  localparam logic [DW-1:0] CAUSE_LOAD = 32'h00C0_0300;
  localparam logic [DW-1:0] CFG0_KEEP  = 32'hFE17_FF80;
  localparam logic [DW-1:0] CFG0_LOAD  = 32'h0000_0001;
  localparam logic [DW-1:0] WHI_LOAD   = 32'h40FF_0FF8;
  localparam logic [DW-1:0] DBG_KEEP   = 32'h8C03_FC1F;
  localparam logic [DW-1:0] DBG_LOAD   = 32'h1330_0120;
  localparam logic [DW-1:0] TAG_LOAD   = 32'hFFFF_FCF6;

  // flag bit positions
  localparam int unsigned B_IE  = 0;
  localparam int unsigned B_EXL = 1;
  localparam int unsigned B_ERL = 2;
  localparam int unsigned B_UM  = 4;
  localparam int unsigned B_DM  = 30;
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode #(
  parameter int unsigned NUM_W = 5
) (
  input  logic                      acc_valid,
  input  logic                      acc_write,
  input  logic [NUM_W-1:0]          acc_num,
  input  logic [2:0]                acc_sel,
  output logic [(1<<NUM_W)-1:0]     wr_hit,
  output logic                      addr_ok,
  output logic                      rd_go
);
  localparam int unsigned NREG = 1 << NUM_W;

  logic [NREG-1:0] num_hit;

  for (genvar n = 0; n < NREG; n++) begin : g_hit
    // only the multi-select slots accept select 1
    localparam bit MULTI = (n == 16) || (n == 28);
    if (MULTI) begin : g_multi
      assign num_hit[n] = (acc_num == NUM_W'(n)) && (acc_sel[2:1] == 2'b00);
    end else begin : g_single
      assign num_hit[n] = (acc_num == NUM_W'(n)) && (acc_sel == 3'd0);
    end
  end

  assign addr_ok = |num_hit;
  assign wr_hit  = (acc_valid && acc_write) ? num_hit : '0;
  assign rd_go   = acc_valid && !acc_write;
endmodule

// File: rtl/sysctl_mode_ctrl.sv
module sysctl_mode_ctrl
  import sysctl_pkg::*;
#(
  parameter int unsigned ASID_W = 8,
  parameter int unsigned IM_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_wr,
  input  logic [DW-1:0]     st_wdata,
  input  logic              st_old_ie,
  input  logic [IM_W-1:0]   cause_im,
  input  logic              dbg_wr,
  input  logic              dbg_wbit,
  input  logic              ehi_wr,
  input  logic [ASID_W-1:0] asid_old,
  input  logic [ASID_W-1:0] asid_new,
  output logic              f_user,
  output logic              f_exl,
  output logic              f_erl,
  output logic              f_dm,
  output logic              irq_req,
  output logic              asid_flush
);
  logic new_ie, raise, withdraw;
  logic [IM_W-1:0] im_new;

  assign new_ie   = st_wdata[B_IE];
  assign im_new   = st_wdata[8 +: IM_W];
  assign raise    = st_wr && new_ie && !st_old_ie && !st_wdata[B_EXL]
                    && !st_wdata[B_ERL] && !f_dm && (|(im_new & cause_im));
  assign withdraw = st_wr && !new_ie && st_old_ie;

  always_ff @(posedge clk) begin
    if (rst) begin
      f_user     <= 1'b0;
      f_exl      <= 1'b0;
      f_erl      <= 1'b0;
      f_dm       <= 1'b0;
      irq_req    <= 1'b0;
      asid_flush <= 1'b0;
    end else begin
      if (st_wr) begin
        f_user <= st_wdata[B_UM];
        f_exl  <= st_wdata[B_EXL];
        f_erl  <= st_wdata[B_ERL];
      end
      if (dbg_wr) f_dm <= dbg_wbit;
      if (raise) irq_req <= 1'b1;
      else if (withdraw) irq_req <= 1'b0;
      asid_flush <= ehi_wr && (asid_old != asid_new);
    end
  end
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter int unsigned    IDX_W     = 4,
  parameter logic [31:0]    PRID_VAL  = 32'h0000_1234,
  parameter logic [31:0]    CFG0_INIT = 32'h8000_0082,
  parameter logic [31:0]    CFG1_VAL  = 32'h1E19_0C8A
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic [4:0]  acc_num,
  input  logic [2:0]  acc_sel,
  input  logic [31:0] acc_wdata,
  input  logic [31:0] rnd_in,
  input  logic [31:0] count_in,
  input  logic [31:0] compare_in,
  input  logic [31:0] badva_in,
  input  logic [31:0] ll_addr_in,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  output logic        asid_flush,
  output logic        irq_req,
  output logic        mode_user,
  output logic        mode_exl,
  output logic        mode_erl,
  output logic        mode_debug,
  output logic        cnt_wr,
  output logic        cmp_wr,
  output logic [31:0] tmr_wdata
);
  localparam int unsigned NUM_W  = 5;
  localparam int unsigned NREG   = 1 << NUM_W;
  localparam int unsigned ASID_W = 8;
  localparam int unsigned IM_W   = 8;
  localparam int unsigned CTX_LO = 4;

  logic [NREG-1:0] wr_hit;
  logic            addr_ok, rd_go;

  // stored state
  logic              idx_miss_q;
  logic [IDX_W-1:0]  idx_q, wired_q;
  logic [DW-1:0]     elo0_q, elo1_q, pmask_q, ehi_q, status_q, cause_q;
  logic [DW-1:0]     epc_q, cfg0_q, wlo_q, whi_q, dbg_q, depc_q, tag_q;
  logic [DW-1:0]     errepc_q, save_q;
  logic [DW-1:CTX_LO] ctx_q;
  logic [DW-1:0]     rd_mux;

  sysctl_decode #(.NUM_W(NUM_W)) u_dec (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_num   (acc_num),
    .acc_sel   (acc_sel),
    .wr_hit    (wr_hit),
    .addr_ok   (addr_ok),
    .rd_go     (rd_go)
  );

  sysctl_mode_ctrl #(.ASID_W(ASID_W), .IM_W(IM_W)) u_mode (
    .clk        (clk),
    .rst        (rst),
    .st_wr      (wr_hit[RN_STATUS]),
    .st_wdata   (acc_wdata),
    .st_old_ie  (status_q[B_IE]),
    .cause_im   (cause_q[8 +: IM_W]),
    .dbg_wr     (wr_hit[RN_DEBUG]),
    .dbg_wbit   (acc_wdata[B_DM]),
    .ehi_wr     (wr_hit[RN_EHI]),
    .asid_old   (ehi_q[ASID_W-1:0]),
    .asid_new   (acc_wdata[ASID_W-1:0]),
    .f_user     (mode_user),
    .f_exl      (mode_exl),
    .f_erl      (mode_erl),
    .f_dm       (mode_debug),
    .irq_req    (irq_req),
    .asid_flush (asid_flush)
  );

  // register writes
  always_ff @(posedge clk) begin
    if (rst) begin
      idx_miss_q <= 1'b0;
      idx_q      <= '0;
      wired_q    <= '0;
      elo0_q     <= '0;
      elo1_q     <= '0;
      ctx_q      <= '0;
      pmask_q    <= '0;
      ehi_q      <= '0;
      status_q   <= '0;
      cause_q    <= '0;
      epc_q      <= '0;
      cfg0_q     <= CFG0_INIT;
      wlo_q      <= '0;
      whi_q      <= '0;
      dbg_q      <= '0;
      depc_q     <= '0;
      tag_q      <= '0;
      errepc_q   <= '0;
      save_q     <= '0;
    end else begin
      if (wr_hit[RN_INDEX])  idx_q    <= acc_wdata[IDX_W-1:0];
      if (wr_hit[RN_ELO0])   elo0_q   <= acc_wdata & ELO_LOAD;
      if (wr_hit[RN_ELO1])   elo1_q   <= acc_wdata & ELO_LOAD;
      if (wr_hit[RN_CTX])    ctx_q    <= {ctx_q[DW-1:24], acc_wdata[23:CTX_LO]};
      if (wr_hit[RN_PMASK])  pmask_q  <= acc_wdata & PMASK_LOAD;
      if (wr_hit[RN_WIRED])  wired_q  <= acc_wdata[IDX_W-1:0];
      if (wr_hit[RN_EHI])    ehi_q    <= acc_wdata & EHI_LOAD;
      if (wr_hit[RN_STATUS]) status_q <= acc_wdata & STAT_LOAD;
      if (wr_hit[RN_CAUSE])  cause_q  <= (cause_q & CAUSE_KEEP) | (acc_wdata & CAUSE_LOAD);
      if (wr_hit[RN_EPC])    epc_q    <= acc_wdata;
      if (wr_hit[RN_CONFIG] && !acc_sel[0])
        cfg0_q <= (cfg0_q & CFG0_KEEP) | (acc_wdata & CFG0_LOAD);
      if (wr_hit[RN_WLO])    wlo_q    <= acc_wdata;
      if (wr_hit[RN_WHI])    whi_q    <= acc_wdata & WHI_LOAD;
      if (wr_hit[RN_DEBUG])  dbg_q    <= (dbg_q & DBG_KEEP) | (acc_wdata & DBG_LOAD);
      if (wr_hit[RN_DEPC])   depc_q   <= acc_wdata;
      if (wr_hit[RN_CACHE] && !acc_sel[0]) tag_q <= acc_wdata & TAG_LOAD;
      if (wr_hit[RN_ERREPC]) errepc_q <= acc_wdata;
      if (wr_hit[RN_SAVE])   save_q   <= acc_wdata;
    end
  end

  // timer write strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_wr    <= 1'b0;
      cmp_wr    <= 1'b0;
      tmr_wdata <= '0;
    end else begin
      cnt_wr <= wr_hit[RN_COUNT];
      cmp_wr <= wr_hit[RN_CMP];
      if (wr_hit[RN_COUNT] || wr_hit[RN_CMP]) tmr_wdata <= acc_wdata;
    end
  end

  // read selection
  always_comb begin
    rd_mux = '0;
    if (addr_ok) begin
      unique case (acc_num)
        RN_INDEX:  rd_mux = {idx_miss_q, {(DW-1-IDX_W){1'b0}}, idx_q};
        RN_RANDOM: rd_mux = rnd_in;
        RN_ELO0:   rd_mux = elo0_q;
        RN_ELO1:   rd_mux = elo1_q;
        RN_CTX:    rd_mux = {ctx_q, {CTX_LO{1'b0}}};
        RN_PMASK:  rd_mux = pmask_q;
        RN_WIRED:  rd_mux = {{(DW-IDX_W){1'b0}}, wired_q};
        RN_BADVA:  rd_mux = badva_in;
        RN_COUNT:  rd_mux = count_in;
        RN_EHI:    rd_mux = ehi_q;
        RN_CMP:    rd_mux = compare_in;
        RN_STATUS: begin
          rd_mux = status_q;
          rd_mux[B_UM]  = mode_user;
          rd_mux[B_ERL] = mode_erl;
          rd_mux[B_EXL] = mode_exl;
        end
        RN_CAUSE:  rd_mux = cause_q;
        RN_EPC:    rd_mux = epc_q;
        RN_PRID:   rd_mux = PRID_VAL;
        RN_CONFIG: rd_mux = acc_sel[0] ? CFG1_VAL : cfg0_q;
        RN_LLADDR: rd_mux = ll_addr_in >> 4;
        RN_WLO:    rd_mux = wlo_q;
        RN_WHI:    rd_mux = whi_q;
        RN_DEBUG:  begin
          rd_mux = dbg_q;
          rd_mux[B_DM] = mode_debug;
        end
        RN_DEPC:   rd_mux = depc_q;
        RN_CACHE:  rd_mux = acc_sel[0] ? '0 : tag_q;
        RN_ERREPC: rd_mux = errepc_q;
        RN_SAVE:   rd_mux = save_q;
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_go;
      if (rd_go) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk (
  input logic        clk,
  input logic        rst,
  input logic        acc_valid,
  input logic        acc_write,
  input logic [4:0]  acc_num,
  input logic [2:0]  acc_sel,
  input logic [31:0] acc_wdata,
  input logic        rd_valid,
  input logic        asid_flush,
  input logic        irq_req,
  input logic        cnt_wr,
  input logic        cmp_wr
);
  logic st_write, bad_write;
  assign st_write  = acc_valid && acc_write && acc_num == 5'd12 && acc_sel == 3'd0;
  assign bad_write = acc_valid && acc_write && acc_sel != 3'd0
                     && acc_num != 5'd16 && acc_num != 5'd28;

  assert_flush_source_R6: assert property (@(posedge clk) disable iff (rst)
    asid_flush |-> $past(acc_valid && acc_write && acc_num == 5'd10 && acc_sel == 3'd0));

  assert_irq_rise_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> $past(st_write && acc_wdata[0]));

  assert_irq_fall_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_req) |-> $past(st_write && !acc_wdata[0]));

  assert_invalid_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    bad_write |=> (!asid_flush && !cnt_wr && !cmp_wr && $stable(irq_req)));

  assert_timer_strobe_R13: assert property (@(posedge clk) disable iff (rst)
    (cnt_wr || cmp_wr) |-> $past(acc_valid && acc_write && acc_sel == 3'd0
                                 && (acc_num == 5'd9 || acc_num == 5'd11)));

  assert_timer_single_R13: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cnt_wr, cmp_wr}));

  assert_read_timing_R14: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(acc_valid && !acc_write));
endmodule

bind sysctl_regfile sysctl_regfile_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .acc_valid  (acc_valid),
  .acc_write  (acc_write),
  .acc_num    (acc_num),
  .acc_sel    (acc_sel),
  .acc_wdata  (acc_wdata),
  .rd_valid   (rd_valid),
  .asid_flush (asid_flush),
  .irq_req    (irq_req),
  .cnt_wr     (cnt_wr),
  .cmp_wr     (cmp_wr)
);

// File: tb/sysctl_regfile_test.sv
module sysctl_regfile_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [4:0]  acc_num = '0;
  logic [2:0]  acc_sel = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] rnd_in = 32'h0000_000B, count_in = 32'h0000_1000;
  logic [31:0] compare_in = 32'h0000_2000, badva_in = 32'hBAD0_0004;
  logic [31:0] ll_addr_in = 32'h0000_ABC0;
  logic        rd_valid, asid_flush, irq_req;
  logic        mode_user, mode_exl, mode_erl, mode_debug, cnt_wr, cmp_wr;
  logic [31:0] rd_data, tmr_wdata;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  sysctl_regfile uut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_num(acc_num), .acc_sel(acc_sel), .acc_wdata(acc_wdata),
    .rnd_in(rnd_in), .count_in(count_in), .compare_in(compare_in),
    .badva_in(badva_in), .ll_addr_in(ll_addr_in),
    .rd_valid(rd_valid), .rd_data(rd_data), .asid_flush(asid_flush),
    .irq_req(irq_req), .mode_user(mode_user), .mode_exl(mode_exl),
    .mode_erl(mode_erl), .mode_debug(mode_debug), .cnt_wr(cnt_wr),
    .cmp_wr(cmp_wr), .tmr_wdata(tmr_wdata)
  );

  // {write, num, sel, data, expected read, tag}
  localparam int NV = 38;
  localparam logic [96:0] VEC [NV] = '{
    {1'b1, 5'd0,  3'd0, 32'hFFFF_FFFF, 32'h0,          "R2 "},
    {1'b0, 5'd0,  3'd0, 32'h0,         32'h0000_000F,  "R2 "},
    {1'b1, 5'd2,  3'd0, 32'hFFFF_FFFF, 32'h0,          "R3 "},
    {1'b0, 5'd2,  3'd0, 32'h0,         32'h3FFF_FFFF,  "R3 "},
    {1'b1, 5'd3,  3'd0, 32'hC000_0001, 32'h0,          "R3 "},
    {1'b0, 5'd3,  3'd0, 32'h0,         32'h0000_0001,  "R3 "},
    {1'b1, 5'd4,  3'd0, 32'hFFFF_FFFF, 32'h0,          "R4 "},
    {1'b0, 5'd4,  3'd0, 32'h0,         32'h00FF_FFF0,  "R4 "},
    {1'b1, 5'd5,  3'd0, 32'hFFFF_FFFF, 32'h0,          "R5 "},
    {1'b0, 5'd5,  3'd0, 32'h0,         32'h01FF_E000,  "R5 "},
    {1'b1, 5'd6,  3'd0, 32'hABCD_EF57, 32'h0,          "R5 "},
    {1'b0, 5'd6,  3'd0, 32'h0,         32'h0000_0007,  "R5 "},
    {1'b1, 5'd19, 3'd0, 32'hFFFF_FFFF, 32'h0,          "R5 "},
    {1'b0, 5'd19, 3'd0, 32'h0,         32'h40FF_0FF8,  "R5 "},
    {1'b1, 5'd28, 3'd0, 32'hFFFF_FFFF, 32'h0,          "R5 "},
    {1'b0, 5'd28, 3'd0, 32'h0,         32'hFFFF_FCF6,  "R5 "},
    {1'b1, 5'd16, 3'd0, 32'hFFFF_FFFF, 32'h0,          "R5 "},
    {1'b0, 5'd16, 3'd0, 32'h0,         32'h8000_0081,  "R5 "},
    {1'b0, 5'd16, 3'd1, 32'h0,         32'h1E19_0C8A,  "R5 "},
    {1'b1, 5'd13, 3'd0, 32'hFFFF_FFFF, 32'h0,          "R5 "},
    {1'b0, 5'd13, 3'd0, 32'h0,         32'h00C0_0300,  "R5 "},
    {1'b1, 5'd14, 3'd1, 32'hDEAD_BEEF, 32'h0,          "R1 "},
    {1'b0, 5'd14, 3'd0, 32'h0,         32'h0000_0000,  "R1 "},
    {1'b1, 5'd14, 3'd0, 32'h0BAD_F00D, 32'h0,          "R1 "},
    {1'b0, 5'd14, 3'd0, 32'h0,         32'h0BAD_F00D,  "R1 "},
    {1'b0, 5'd2,  3'd3, 32'h0,         32'h0000_0000,  "R1 "},
    {1'b0, 5'd16, 3'd2, 32'h0,         32'h0000_0000,  "R1 "},
    {1'b1, 5'd7,  3'd0, 32'hFFFF_FFFF, 32'h0,          "R12"},
    {1'b0, 5'd7,  3'd0, 32'h0,         32'h0000_0000,  "R12"},
    {1'b0, 5'd15, 3'd0, 32'h0,         32'h0000_1234,  "R12"},
    {1'b0, 5'd1,  3'd0, 32'h0,         32'h0000_000B,  "R12"},
    {1'b0, 5'd8,  3'd0, 32'h0,         32'hBAD0_0004,  "R12"},
    {1'b0, 5'd17, 3'd0, 32'h0,         32'h0000_0ABC,  "R10"},
    {1'b1, 5'd12, 3'd0, 32'hFFFF_FFFF, 32'h0,          "R7 "},
    {1'b0, 5'd12, 3'd0, 32'h0,         32'hFA78_FF17,  "R7 "},
    {1'b1, 5'd23, 3'd0, 32'hFFFF_FFFF, 32'h0,          "R11"},
    {1'b0, 5'd23, 3'd0, 32'h0,         32'h5330_0120,  "R11"},
    {1'b0, 5'd9,  3'd0, 32'h0,         32'h0000_1000,  "R12"}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_acc(input logic [4:0] n, input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_num = n; acc_sel = s; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic rd_acc(input logic [4:0] n, input logic [2:0] s,
                        output logic [31:0] q, output logic v);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_num = n; acc_sel = s;
    @(negedge clk);
    acc_valid = 1'b0;
    q = rd_data;
    v = rd_valid;
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    report();
    $finish;
  end

  initial begin
    logic [31:0] q;
    logic v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // reset state
    check("R9 reset irq", {31'b0, irq_req}, 32'h0);
    check("R6 reset flush", {31'b0, asid_flush}, 32'h0);
    rd_acc(5'd12, 3'd0, q, v);
    check("R7 reset status", q, 32'h0);
    rd_acc(5'd16, 3'd0, q, v);
    check("R5 reset config0", q, 32'h8000_0082);
    check("R14 read valid", {31'b0, v}, 32'h1);
    @(negedge clk);
    check("R14 valid drops", {31'b0, rd_valid}, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][96]) begin
        wr_acc(VEC[i][95:91], VEC[i][90:88], VEC[i][87:56]);
      end else begin
        rd_acc(VEC[i][95:91], VEC[i][90:88], q, v);
        check(string'(VEC[i][23:0]), q, VEC[i][55:24]);
      end
    end

    // R13 timer strobes
    wr_acc(5'd9, 3'd0, 32'h0000_0055);
    check("R13 count strobe", {30'b0, cnt_wr, cmp_wr}, 32'h2);
    check("R13 timer data", tmr_wdata, 32'h0000_0055);
    wr_acc(5'd11, 3'd0, 32'h0000_0077);
    check("R13 compare strobe", {30'b0, cnt_wr, cmp_wr}, 32'h1);
    check("R13 timer data", tmr_wdata, 32'h0000_0077);
    @(negedge clk);
    check("R13 strobe ends", {30'b0, cnt_wr, cmp_wr}, 32'h0);
    rd_acc(5'd11, 3'd0, q, v);
    check("R12 compare input", q, 32'h0000_2000);

    // R6 flush
    wr_acc(5'd10, 3'd0, 32'h1234_5F78);
    check("R6 asid change flush", {31'b0, asid_flush}, 32'h1);
    @(negedge clk);
    check("R6 flush one cycle", {31'b0, asid_flush}, 32'h0);
    rd_acc(5'd10, 3'd0, q, v);
    check("R6 entryhi mask", q, 32'h1234_5078);
    wr_acc(5'd10, 3'd0, 32'h9ABC_D078);
    check("R6 same asid no flush", {31'b0, asid_flush}, 32'h0);
    wr_acc(5'd10, 3'd0, 32'h9ABC_D079);
    check("R6 asid change flush", {31'b0, asid_flush}, 32'h1);
    wr_acc(5'd10, 3'd1, 32'h0000_0000);
    check("R1 invalid no flush", {31'b0, asid_flush}, 32'h0);

    // interrupt sequence: clean flags first
    wr_acc(5'd23, 3'd0, 32'h0000_0000);
    check("R11 debug flag clear", {31'b0, mode_debug}, 32'h0);
    wr_acc(5'd12, 3'd0, 32'h0000_0000);
    check("R7 flags cleared", {29'b0, mode_user, mode_erl, mode_exl}, 32'h0);
    wr_acc(5'd13, 3'd0, 32'h0000_0000);
    wr_acc(5'd12, 3'd0, 32'h0000_0101);
    check("R8 no pending no irq", {31'b0, irq_req}, 32'h0);
    wr_acc(5'd12, 3'd0, 32'h0000_0100);
    wr_acc(5'd13, 3'd0, 32'h0000_0100);
    wr_acc(5'd12, 3'd0, 32'h0000_0103);
    check("R8 exl blocks irq", {31'b0, irq_req}, 32'h0);
    wr_acc(5'd12, 3'd0, 32'h0000_0100);
    wr_acc(5'd23, 3'd0, 32'h4000_0000);
    rd_acc(5'd23, 3'd0, q, v);
    check("R11 debug flag read", q, 32'h4000_0000);
    wr_acc(5'd12, 3'd0, 32'h0000_0101);
    check("R8 debug blocks irq", {31'b0, irq_req}, 32'h0);
    wr_acc(5'd12, 3'd0, 32'h0000_0100);
    wr_acc(5'd23, 3'd0, 32'h0000_0000);
    wr_acc(5'd12, 3'd0, 32'h0000_0001);
    check("R8 masked no irq", {31'b0, irq_req}, 32'h0);
    wr_acc(5'd12, 3'd0, 32'h0000_0100);
    wr_acc(5'd12, 3'd0, 32'h0000_0101);
    check("R8 irq raised", {31'b0, irq_req}, 32'h1);
    wr_acc(5'd12, 3'd2, 32'h0000_0000);
    check("R1 invalid keeps irq", {31'b0, irq_req}, 32'h1);
    wr_acc(5'd12, 3'd0, 32'h0000_0101);
    check("R9 ie held keeps irq", {31'b0, irq_req}, 32'h1);
    wr_acc(5'd12, 3'd0, 32'h0000_0100);
    check("R9 irq withdrawn", {31'b0, irq_req}, 32'h0);
    rd_acc(5'd12, 3'd0, q, v);
    check("R7 status readback", q, 32'h0000_0100);

    report();
    $finish;
  end
endmodule